// File: doc/BRIEF.md
# Least-Recently-Used Thread Select Scheduler

This block sits between per-thread instruction buffers and an instruction decoder in a core that runs eight hardware threads. Every clock it looks at which threads are able to issue and hands the decode stage at most one thread together with the number of instructions that thread may send, never more than two. A thread is either Ready or in Wait. It is held in Wait while a post-synchronization condition is pending, while a mispredicted branch is being recovered, or while its instruction buffer is empty.

Among the Ready threads, the scheduler grants the one that has gone longest without a grant. It tracks this with an ordered list of thread numbers, from the oldest grant to the most recent. When decode raises its stall input, no grant is issued and the list is left as it was. Thread readiness is sampled into a register before it is used. A thread that becomes able to issue in one cycle therefore competes in the following cycle.

Top module: `thread_pick_lru`

## Requirements
- R1: While reset is asserted and after it is released, `sel_valid` is 0, `sel_tid` is 0 and `sel_count` is 0 until the first grant. The grant-age list starts with thread 0 as the oldest and thread 7 as the newest.
- R2: At most one thread is granted per cycle. `sel_tid` is the granted thread's number, 0 to 7. Whenever `sel_valid` is 0, `sel_tid` and `sel_count` are both 0.
- R3: A thread is Ready only if its `post_sync_wait` bit is 0, its `mispredict_wait` bit is 0 and its 4-bit buffer count (bits [4t+3:4t] of `ibuf_count` for thread t) is non-zero. Otherwise it is in Wait and cannot be granted.
- R4: If one or more threads are Ready, the grant goes to the Ready thread that stands earliest in the grant-age list.
- R5: When a grant is issued, the granted thread moves to the newest end of the list. Threads that stood behind it each move one place toward the oldest end. Threads ahead of it keep their places.
- R6: `sel_count` equals the smaller of 2 and the granted thread's buffer count. It is 1 or 2 whenever `sel_valid` is 1.
- R7: While `dn_stall` is 1 at a clock edge, no grant is issued at that edge and the grant-age list is unchanged.
- R8: Readiness is registered. Inputs present at edge k decide the grant that appears after edge k+1, so a thread that becomes Ready is granted at the earliest one edge after it is sampled.
- R9: If no thread is Ready, no grant is issued and the grant-age list is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| post_sync_wait | input | 8 | Per-thread post-synchronization wait cause |
| mispredict_wait | input | 8 | Per-thread branch-mispredict wait cause |
| ibuf_count | input | 32 | Per-thread buffered instruction count, 4 bits per thread |
| dn_stall | input | 1 | Decode stall; blocks granting at this edge |
| sel_valid | output | 1 | A thread was granted this cycle |
| sel_tid | output | 3 | Granted thread number |
| sel_count | output | 2 | Instructions sent for the granted thread, 0 to 2 |

## Verification
The wait causes and buffer counts are sampled at one rising edge. The grant they produce, with its thread number and count, is registered at the next rising edge, and `dn_stall` acts at that second edge. The bench drives every input on the falling edge. A behavioural model keeps the sampled readiness of the previous edge and the age list as a queue, and it advances at each rising edge in the same order as the design. The registered outputs are compared with the model at each falling edge, before new inputs are applied. Separate directed checks confirm the one-cycle readiness delay and that a stall or an all-Wait cycle leaves the age order unchanged.

// File: rtl/tlp_pkg.sv
package tlp_pkg;

    localparam int unsigned ISSUE_MAX = 2;

    typedef logic [1:0] issue_t;

    // Clip a buffered instruction count to the per-cycle issue limit.
    function automatic issue_t clip_issue(input int unsigned n);
        if (n >= ISSUE_MAX) begin
            return issue_t'(ISSUE_MAX);
        end
        return issue_t'(n);
    endfunction

endpackage

// File: rtl/tlp_ready.sv
module tlp_ready
    import tlp_pkg::*;
#(
    parameter int NTHR = 8,
    parameter int CNTW = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NTHR-1:0]        post_sync_wait,
    input  logic [NTHR-1:0]        mispredict_wait,
    input  logic [NTHR*CNTW-1:0]   ibuf_count,
    output logic [NTHR-1:0]        rdy_q,
    output issue_t [NTHR-1:0]      icnt_q
);

    typedef struct packed {
        logic [NTHR-1:0]   rdy;
        issue_t [NTHR-1:0] cnt;
    } rdy_state_t;

    rdy_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int t = 0; t < NTHR; t++) begin
            logic [CNTW-1:0] c;
            c = ibuf_count[t*CNTW +: CNTW];
            st_d.rdy[t] = !post_sync_wait[t] && !mispredict_wait[t] && (c != '0);
            st_d.cnt[t] = clip_issue(int'(c));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdy_q  = st_q.rdy;
    assign icnt_q = st_q.cnt;

    for (genvar g = 0; g < NTHR; g++) begin : g_chk
        AST_WAIT_CAUSE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
            (post_sync_wait[g] || mispredict_wait[g]) |=> !rdy_q[g]); // R3
        AST_EMPTY_BUF_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
            (ibuf_count[g*CNTW +: CNTW] == '0) |=> !rdy_q[g]); // R3
    end

endmodule

// File: rtl/tlp_lru.sv
module tlp_lru #(
    parameter int NTHR = 8,
    parameter int TIDW = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NTHR-1:0] rdy,
    input  logic            advance,
    output logic            hit,
    output logic [TIDW-1:0] win_tid
);

    typedef struct packed {
        logic [NTHR-1:0][TIDW-1:0] order;
    } lru_state_t;

    lru_state_t st_d, st_q;
    int pos;
    logic [NTHR-1:0] seen;

    // Oldest-first search for a ready thread.
    always_comb begin
        hit = 1'b0;
        pos = 0;
        for (int i = 0; i < NTHR; i++) begin
            if (!hit && rdy[st_q.order[i]]) begin
                hit = 1'b1;
                pos = i;
            end
        end
        win_tid = st_q.order[pos];
    end

    // Remove winner, close the gap, append winner at newest end.
    always_comb begin
        st_d = st_q;
        if (advance && hit) begin
            for (int i = 0; i < NTHR - 1; i++) begin
                if (i >= pos) begin
                    st_d.order[i] = st_q.order[i+1];
                end
            end
            st_d.order[NTHR-1] = win_tid;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NTHR; i++) begin
                st_q.order[i] <= TIDW'(i);
            end
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        seen = '0;
        for (int i = 0; i < NTHR; i++) begin
            seen[st_q.order[i]] = 1'b1;
        end
    end

    AST_ORDER_IS_PERM: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(seen) == NTHR); // R5
    AST_WINNER_TO_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && hit) |=> st_q.order[NTHR-1] == $past(win_tid)); // R5
    AST_STALL_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
        !advance |=> $stable(st_q.order)); // R7
    AST_IDLE_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> $stable(st_q.order)); // R9

endmodule

// File: rtl/thread_pick_lru.sv
module thread_pick_lru
    import tlp_pkg::*;
#(
    parameter int NTHR = 8,
    parameter int CNTW = 4,
    parameter int TIDW = $clog2(NTHR)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NTHR-1:0]      post_sync_wait,
    input  logic [NTHR-1:0]      mispredict_wait,
    input  logic [NTHR*CNTW-1:0] ibuf_count,
    input  logic                 dn_stall,
    output logic                 sel_valid,
    output logic [TIDW-1:0]      sel_tid,
    output logic [1:0]           sel_count
);

    typedef struct packed {
        logic            v;
        logic [TIDW-1:0] tid;
        issue_t          cnt;
    } grant_t;

    logic [NTHR-1:0]   rdy_q;
    issue_t [NTHR-1:0] icnt_q;
    logic              hit;
    logic [TIDW-1:0]   win_tid;
    grant_t            gr_d, gr_q;

    tlp_ready #(.NTHR(NTHR), .CNTW(CNTW)) u_ready (
        .clk             (clk),
        .rst_n           (rst_n),
        .post_sync_wait  (post_sync_wait),
        .mispredict_wait (mispredict_wait),
        .ibuf_count      (ibuf_count),
        .rdy_q           (rdy_q),
        .icnt_q          (icnt_q)
    );

    tlp_lru #(.NTHR(NTHR), .TIDW(TIDW)) u_lru (
        .clk     (clk),
        .rst_n   (rst_n),
        .rdy     (rdy_q),
        .advance (!dn_stall),
        .hit     (hit),
        .win_tid (win_tid)
    );

    always_comb begin
        gr_d = '0;
        if (hit && !dn_stall) begin
            gr_d.v   = 1'b1;
            gr_d.tid = win_tid;
            gr_d.cnt = icnt_q[win_tid];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gr_q <= '0;
        end else begin
            gr_q <= gr_d;
        end
    end

    assign sel_valid = gr_q.v;
    assign sel_tid   = gr_q.tid;
    assign sel_count = gr_q.cnt;

    AST_GRANT_HAS_WORK: assert property (@(posedge clk) disable iff (!rst_n)
        sel_valid |-> (sel_count == 2'd1 || sel_count == 2'd2)); // R6
    AST_STALL_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        dn_stall |=> !sel_valid); // R7
    AST_IDLE_OUTPUTS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_valid |-> (sel_tid == '0 && sel_count == 2'd0)); // R2

endmodule

// File: tb/sim_thread_pick_lru.sv
module sim_thread_pick_lru;

    localparam int NT = 8;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NT-1:0] ps = '0;
    logic [NT-1:0] mp = '0;
    logic [NT*CW-1:0] cnt = '0;
    logic          stall = 1'b0;
    logic          sel_valid;
    logic [2:0]    sel_tid;
    logic [1:0]    sel_count;

    int total = 0;
    int bad = 0;
    string tag = "R1";

    always #4 clk = ~clk;

    thread_pick_lru u0 (
        .clk(clk), .rst_n(rst_n), .post_sync_wait(ps), .mispredict_wait(mp),
        .ibuf_count(cnt), .dn_stall(stall),
        .sel_valid(sel_valid), .sel_tid(sel_tid), .sel_count(sel_count)
    );

    // Behavioural reference model
    int m_q[$];
    bit m_rdy[NT];
    int m_cnt[NT];
    bit e_v;
    int e_tid, e_cnt;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_q = {};
            for (int i = 0; i < NT; i++) begin
                m_q.push_back(i);
                m_rdy[i] = 0;
                m_cnt[i] = 0;
            end
            e_v = 0; e_tid = 0; e_cnt = 0;
        end else begin
            e_v = 0; e_tid = 0; e_cnt = 0;
            if (!stall) begin
                for (int i = 0; i < NT; i++) begin
                    if (!e_v && m_rdy[m_q[i]]) begin
                        e_v = 1;
                        e_tid = m_q[i];
                        e_cnt = m_cnt[m_q[i]];
                        m_q.delete(i);
                        m_q.push_back(e_tid);
                    end
                end
            end
            for (int i = 0; i < NT; i++) begin
                int c;
                c = int'(cnt[i*CW +: CW]);
                m_rdy[i] = !ps[i] && !mp[i] && (c != 0);
                m_cnt[i] = (c > 2) ? 2 : c;
            end
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
        end
    endtask

    task automatic cmp_model();
        chk(tag, "valid", int'(sel_valid), int'(e_v));
        chk(tag, "tid",   int'(sel_tid),   e_tid);
        chk(tag, "count", int'(sel_count), e_cnt);
    endtask

    task automatic set_cnt(input int t, input int v);
        cnt[t*CW +: CW] = CW'(v);
    endtask

    task automatic step();
        @(negedge clk);
        cmp_model();
    endtask

    initial begin
        // R1: reset state
        repeat (3) begin
            @(negedge clk);
            chk("R1", "valid in reset", int'(sel_valid), 0);
            chk("R1", "count in reset", int'(sel_count), 0);
        end
        for (int t = 0; t < NT; t++) set_cnt(t, 5);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R8", "valid one edge after first sample", int'(sel_valid), 0);
        @(negedge clk);
        chk("R1", "first grant is thread 0", int'(sel_tid), 0);
        chk("R1", "first grant valid", int'(sel_valid), 1);

        // R4/R5: all ready, round robin via age order
        tag = "R4";
        repeat (12) step();

        // R6: various counts
        tag = "R6";
        for (int t = 0; t < NT; t++) set_cnt(t, (t % 4));
        repeat (12) step();
        set_cnt(3, 15); set_cnt(5, 2);
        repeat (8) step();

        // R3: wait causes
        tag = "R3";
        for (int t = 0; t < NT; t++) set_cnt(t, 3);
        ps = 8'b0001_0010; mp = 8'b1000_0100;
        repeat (10) step();
        ps = '0; mp = '0;

        // R7: stall keeps order
        tag = "R7";
        stall = 1'b1;
        repeat (4) step();
        stall = 1'b0;
        repeat (6) step();
        @(negedge clk);
        stall = 1'b1;
        @(negedge clk);
        chk("R7", "no grant while stalled", int'(sel_valid), 0);
        cmp_model();
        stall = 1'b0;

        // R9 then R8: nothing ready, then thread 5 alone
        tag = "R9";
        ps = '1;
        repeat (4) step();
        chk("R9", "no grant when all wait", int'(sel_valid), 0);
        ps = 8'b1101_1111;
        @(negedge clk);
        cmp_model();
        chk("R8", "not granted in sample cycle", int'(sel_valid), 0);
        @(negedge clk);
        cmp_model();
        chk("R8", "granted next cycle", int'(sel_tid), 5);
        chk("R8", "granted valid next cycle", int'(sel_valid), 1);
        ps = '0;

        // R2/R5: mixed random traffic
        tag = "R5";
        for (int n = 0; n < 400; n++) begin
            @(negedge clk);
            cmp_model();
            ps = NT'($urandom);
            mp = NT'($urandom) & NT'($urandom);
            for (int t = 0; t < NT; t++) set_cnt(t, $urandom_range(0, 4));
            stall = ($urandom_range(0, 5) == 0);
            if (n > 200) tag = "R2";
        end
        stall = 1'b0;
        repeat (3) step();

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired act=1 exp=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule